// File: doc/BRIEF.md
# Compressed Instruction Mode Sequencer

This block tracks whether the instruction stream is being decoded as full-width 32-bit instructions or as 16-bit compressed halfwords, and it works out the decode mode for the instruction that follows. It runs in step with the decoder. On each valid instruction it receives the compressed halfword, a one-bit "enter compressed" indication from the decoder, a narrow-form flag and the decoder's primary opcode class. It returns three things: the mode that applies to the current instruction, the mode that will apply to the next one, and the opcode class after any alternate-meaning remap.

In compressed mode the two outermost bits of the halfword act as a mode-control field. This field can keep the stream compressed, return it to 32-bit decode for good, or leave compressed mode for a single 32-bit instruction. After that single instruction the stream comes back to compressed mode with no re-entry instruction. The fourth value of the field is reserved. The block raises a one-cycle flag for it and stays in compressed mode.

The spare bit next to the upper control bit selects an alternate meaning for two opcode pairs: multiply becomes divide, and absolute value becomes register move. This remap applies only to the full 16-bit compressed form and never to the narrow form.

Top module: `cmode_seq`

## Requirements
- R1: A synchronous reset sets `cur_mode` to FULL32 (encoding 0) and clears `resv_flag`. Reset wins over a valid instruction in the same cycle.
- R2: In FULL32, a valid instruction with `enter_comp`=1 makes `cur_mode` COMP16 (encoding 1) on the next cycle. A valid instruction with `enter_comp`=0 keeps FULL32. In the other modes `enter_comp` has no effect.
- R3: In COMP16, a valid halfword whose control field {insn_half[15], insn_half[0]} is 0b01 keeps COMP16.
- R4: In COMP16, control 0b00 moves to FULL32. FULL32 is then held across any control values until `enter_comp` is seen.
- R5: In COMP16, control 0b10 moves to TEMP32 (encoding 2) for exactly one valid instruction. The next valid instruction returns the mode to COMP16, whatever its halfword bits or `enter_comp` are.
- R6: In COMP16, control 0b11 keeps COMP16 and raises `resv_flag` during the cycle after that instruction, for that one cycle only. Consecutive reserved instructions keep the flag high. Control bits seen in FULL32 or TEMP32 never raise it.
- R7: While `insn_vld`=0, `cur_mode` holds and `resv_flag` is 0 on the following cycle.
- R8: In COMP16, with alternate bit insn_half[14]=1 and `narrow_form`=0, class FMUL (1) becomes FDIV (2) and class FABS (3) becomes FMR (4) on `op_cls_out` in the same cycle.
- R9: `op_cls_out` equals `op_cls_in` when the alternate bit is 0, when `narrow_form`=1, when the mode is not COMP16, or when the class is neither FMUL nor FABS (OTHER=0, FDIV=2 pass unchanged).
- R10: `next_mode` shows in the same cycle the mode that `cur_mode` takes after the edge. With `insn_vld`=0 it equals `cur_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_vld | input | 1 | Instruction valid strobe; low means stall |
| insn_half | input | 16 | Compressed halfword (control and alternate bits) |
| enter_comp | input | 1 | Decoder saw the enter-compressed instruction |
| narrow_form | input | 1 | Current compressed instruction is the narrow form |
| op_cls_in | input | 3 | Primary opcode class from decoder |
| cur_mode | output | 2 | Mode applying to the current instruction |
| next_mode | output | 2 | Mode for the next instruction |
| op_cls_out | output | 3 | Opcode class after alternate remap |
| resv_flag | output | 1 | Reserved-control pulse, one cycle after the instruction |

## Verification
`next_mode` and `op_cls_out` are combinational, so they are due in the same cycle as the instruction presented. `cur_mode` changes one rising edge after a valid instruction. `resv_flag` is registered and is high only during the cycle after the reserved instruction. The bench applies each vector at a falling edge and samples a quarter period later. At that point the same-cycle outputs refer to the vector just applied, while `cur_mode` and `resv_flag` refer to the previous vector. The expected values in the table are written on that basis.

// File: rtl/cmode_seq_pkg.sv
`timescale 1ns/1ps
package cmode_seq_pkg;

    typedef enum logic [1:0] {
        MODE_FULL32 = 2'd0,
        MODE_COMP16 = 2'd1,
        MODE_TEMP32 = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        CTL_EXIT = 2'b00,
        CTL_STAY = 2'b01,
        CTL_ONCE = 2'b10,
        CTL_RESV = 2'b11
    } ctl_e;

    localparam int CLS_W     = 3;
    localparam int NUM_PAIRS = 2;

    typedef logic [CLS_W-1:0] cls_t;

    localparam cls_t CLS_OTHER = 3'd0;
    localparam cls_t CLS_FMUL  = 3'd1;
    localparam cls_t CLS_FDIV  = 3'd2;
    localparam cls_t CLS_FABS  = 3'd3;
    localparam cls_t CLS_FMR   = 3'd4;

    typedef struct packed {
        ctl_e ctl;
        logic alt;
    } half_ctl_t;

    function automatic cls_t pair_primary(input int idx);
        return (idx == 0) ? CLS_FMUL : CLS_FABS;
    endfunction

    function automatic cls_t pair_alternate(input int idx);
        return (idx == 0) ? CLS_FDIV : CLS_FMR;
    endfunction

endpackage

// File: rtl/cmode_seq_field.sv
`timescale 1ns/1ps
module cmode_seq_field
    import cmode_seq_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic [HALF_W-1:0] half_in,
    output half_ctl_t         fld
);
    localparam int CTL_HI_POS = HALF_W - 1;
    localparam int CTL_LO_POS = 0;
    localparam int ALT_POS    = HALF_W - 2;

    always_comb begin
        fld.ctl = ctl_e'({half_in[CTL_HI_POS], half_in[CTL_LO_POS]});
        fld.alt = half_in[ALT_POS];
    end
endmodule

// File: rtl/cmode_seq_fsm.sv
`timescale 1ns/1ps
module cmode_seq_fsm
    import cmode_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  vld,
    input  logic  enter,
    input  ctl_e  ctl,
    output mode_e mode_q,
    output mode_e mode_nxt,
    output logic  resv_q
);
    logic resv_d;

    always_comb begin
        mode_nxt = mode_q;
        resv_d   = 1'b0;
        if (vld) begin
            unique case (mode_q)
                MODE_FULL32: begin
                    if (enter) mode_nxt = MODE_COMP16;
                end
                MODE_COMP16: begin
                    unique case (ctl)
                        CTL_EXIT: mode_nxt = MODE_FULL32;
                        CTL_STAY: mode_nxt = MODE_COMP16;
                        CTL_ONCE: mode_nxt = MODE_TEMP32;
                        CTL_RESV: begin
                            mode_nxt = MODE_COMP16;
                            resv_d   = 1'b1;
                        end
                        default:  mode_nxt = MODE_COMP16;
                    endcase
                end
                MODE_TEMP32: mode_nxt = MODE_COMP16;
                default:     mode_nxt = MODE_FULL32;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_FULL32;
            resv_q <= 1'b0;
        end else begin
            mode_q <= mode_nxt;
            resv_q <= resv_d;
        end
    end
endmodule

// File: rtl/cmode_seq_remap.sv
`timescale 1ns/1ps
module cmode_seq_remap
    import cmode_seq_pkg::*;
(
    input  mode_e mode,
    input  logic  alt,
    input  logic  narrow,
    input  cls_t  cls_in,
    output cls_t  cls_out
);
    logic [NUM_PAIRS-1:0] hit;
    cls_t                 alt_val [NUM_PAIRS];
    logic                 remap_en;

    assign remap_en = (mode == MODE_COMP16) && alt && !narrow;

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        assign hit[p]     = (cls_in == pair_primary(p));
        assign alt_val[p] = pair_alternate(p);
    end

    always_comb begin
        cls_out = cls_in;
        if (remap_en) begin
            for (int p = 0; p < NUM_PAIRS; p++) begin
                if (hit[p]) cls_out = alt_val[p];
            end
        end
    end
endmodule

// File: rtl/cmode_seq.sv
`timescale 1ns/1ps
module cmode_seq
    import cmode_seq_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              insn_vld,
    input  logic [HALF_W-1:0] insn_half,
    input  logic              enter_comp,
    input  logic              narrow_form,
    input  logic [CLS_W-1:0]  op_cls_in,
    output logic [1:0]        cur_mode,
    output logic [1:0]        next_mode,
    output logic [CLS_W-1:0]  op_cls_out,
    output logic              resv_flag
);
    half_ctl_t fld;
    mode_e     mode_q;
    mode_e     mode_nxt;
    logic      unused_body;

    assign unused_body = ^insn_half[HALF_W-3:1];

    cmode_seq_field #(.HALF_W(HALF_W)) u_field (
        .half_in (insn_half),
        .fld     (fld)
    );

    cmode_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .vld      (insn_vld),
        .enter    (enter_comp),
        .ctl      (fld.ctl),
        .mode_q   (mode_q),
        .mode_nxt (mode_nxt),
        .resv_q   (resv_flag)
    );

    cmode_seq_remap u_remap (
        .mode    (mode_q),
        .alt     (fld.alt),
        .narrow  (narrow_form),
        .cls_in  (op_cls_in),
        .cls_out (op_cls_out)
    );

    assign cur_mode  = mode_q;
    assign next_mode = mode_nxt;
endmodule

// File: rtl/cmode_seq_chk.sv
`timescale 1ns/1ps
module cmode_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        insn_vld,
    input logic [15:0] insn_half,
    input logic        enter_comp,
    input logic        narrow_form,
    input logic [2:0]  op_cls_in,
    input logic [1:0]  cur_mode,
    input logic [1:0]  next_mode,
    input logic [2:0]  op_cls_out,
    input logic        resv_flag
);
    logic [1:0] ctl;
    assign ctl = {insn_half[15], insn_half[0]};

    p_enter_r2: assert property (@(posedge clk) disable iff (rst)
        (insn_vld && cur_mode == 2'd0 && enter_comp) |=> (cur_mode == 2'd1));

    p_stay_r3: assert property (@(posedge clk) disable iff (rst)
        (insn_vld && cur_mode == 2'd1 && ctl == 2'b01) |=> (cur_mode == 2'd1));

    p_excursion_r5: assert property (@(posedge clk) disable iff (rst)
        (insn_vld && cur_mode == 2'd2) |=> (cur_mode == 2'd1));

    p_resv_src_r6: assert property (@(posedge clk) disable iff (rst)
        resv_flag |-> $past(insn_vld && cur_mode == 2'd1 && ctl == 2'b11));

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !insn_vld |=> ($stable(cur_mode) && !resv_flag));

    p_remap_r8: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == 2'd1 && insn_half[14] && !narrow_form && op_cls_in == 3'd1)
        |-> (op_cls_out == 3'd2));

    p_noremap_r9: assert property (@(posedge clk) disable iff (rst)
        (cur_mode != 2'd1 || narrow_form) |-> (op_cls_out == op_cls_in));

    p_next_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cur_mode == $past(next_mode)));
endmodule

bind cmode_seq cmode_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .insn_vld    (insn_vld),
    .insn_half   (insn_half),
    .enter_comp  (enter_comp),
    .narrow_form (narrow_form),
    .op_cls_in   (op_cls_in),
    .cur_mode    (cur_mode),
    .next_mode   (next_mode),
    .op_cls_out  (op_cls_out),
    .resv_flag   (resv_flag)
);

// File: tb/cmode_seq_tb.sv
`timescale 1ns/1ps
module cmode_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        insn_vld = 1'b0;
    logic [15:0] insn_half = 16'h0;
    logic        enter_comp = 1'b0;
    logic        narrow_form = 1'b0;
    logic [2:0]  op_cls_in = 3'd0;
    logic [1:0]  cur_mode;
    logic [1:0]  next_mode;
    logic [2:0]  op_cls_out;
    logic        resv_flag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cmode_seq u_dut (
        .clk (clk), .rst (rst), .insn_vld (insn_vld), .insn_half (insn_half),
        .enter_comp (enter_comp), .narrow_form (narrow_form), .op_cls_in (op_cls_in),
        .cur_mode (cur_mode), .next_mode (next_mode), .op_cls_out (op_cls_out),
        .resv_flag (resv_flag)
    );

    // [16]vld [15]enter [14]narrow [13:12]ctl [11]alt [10:8]cls
    // [7:6]exp cur_mode [5:4]exp next_mode [3:1]exp cls_out [0]exp resv_flag
    localparam int NV = 20;
    localparam logic [16:0] VEC [NV] = '{
        {1'b1,1'b0,1'b0,2'b11,1'b1,3'd1, 2'd0,2'd0,3'd1,1'b0},
        {1'b1,1'b1,1'b0,2'b00,1'b0,3'd0, 2'd0,2'd1,3'd0,1'b0},
        {1'b1,1'b0,1'b0,2'b01,1'b1,3'd1, 2'd1,2'd1,3'd2,1'b0},
        {1'b1,1'b0,1'b0,2'b01,1'b1,3'd3, 2'd1,2'd1,3'd4,1'b0},
        {1'b1,1'b0,1'b0,2'b01,1'b0,3'd1, 2'd1,2'd1,3'd1,1'b0},
        {1'b1,1'b0,1'b1,2'b01,1'b1,3'd3, 2'd1,2'd1,3'd3,1'b0},
        {1'b1,1'b0,1'b0,2'b11,1'b0,3'd0, 2'd1,2'd1,3'd0,1'b0},
        {1'b0,1'b0,1'b0,2'b01,1'b0,3'd0, 2'd1,2'd1,3'd0,1'b1},
        {1'b0,1'b0,1'b0,2'b00,1'b0,3'd0, 2'd1,2'd1,3'd0,1'b0},
        {1'b1,1'b0,1'b0,2'b10,1'b1,3'd2, 2'd1,2'd2,3'd2,1'b0},
        {1'b0,1'b1,1'b0,2'b00,1'b0,3'd0, 2'd2,2'd2,3'd0,1'b0},
        {1'b1,1'b0,1'b0,2'b00,1'b1,3'd1, 2'd2,2'd1,3'd1,1'b0},
        {1'b1,1'b0,1'b0,2'b11,1'b0,3'd0, 2'd1,2'd1,3'd0,1'b0},
        {1'b1,1'b0,1'b0,2'b11,1'b0,3'd0, 2'd1,2'd1,3'd0,1'b1},
        {1'b1,1'b0,1'b0,2'b00,1'b0,3'd0, 2'd1,2'd0,3'd0,1'b1},
        {1'b1,1'b0,1'b0,2'b01,1'b1,3'd1, 2'd0,2'd0,3'd1,1'b0},
        {1'b1,1'b1,1'b0,2'b10,1'b0,3'd0, 2'd0,2'd1,3'd0,1'b0},
        {1'b1,1'b1,1'b0,2'b10,1'b0,3'd3, 2'd1,2'd2,3'd3,1'b0},
        {1'b1,1'b0,1'b0,2'b11,1'b0,3'd0, 2'd2,2'd1,3'd0,1'b0},
        {1'b0,1'b0,1'b0,2'b01,1'b0,3'd0, 2'd1,2'd1,3'd0,1'b0}
    };

    function automatic string tag_of(input int i);
        case (i)
            0:       return "R10";
            1, 16:   return "R2";
            2:       return "R3";
            3:       return "R8";
            4, 5:    return "R9";
            6, 7, 12, 13: return "R6";
            8, 10:   return "R7";
            14, 15:  return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #5;
        check("R1", "cur_mode after reset", int'(cur_mode), 0);
        check("R1", "resv_flag after reset", int'(resv_flag), 0);
        check("R10", "next_mode idle", int'(next_mode), 0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [16:0] v;
            v = VEC[i];
            @(negedge clk);
            insn_vld    = v[16];
            enter_comp  = v[15];
            narrow_form = v[14];
            insn_half   = {v[13], v[11], 13'h0A5, v[12]};
            op_cls_in   = v[10:8];
            #5;
            check(tag_of(i), $sformatf("vec%0d cur_mode", i), int'(cur_mode), int'(v[7:6]));
            check("R10",     $sformatf("vec%0d next_mode", i), int'(next_mode), int'(v[5:4]));
            check(tag_of(i), $sformatf("vec%0d op_cls_out", i), int'(op_cls_out), int'(v[3:1]));
            check(tag_of(i), $sformatf("vec%0d resv_flag", i), int'(resv_flag), int'(v[0]));
        end

        // reset wins over a reserved instruction in COMP16
        @(negedge clk);
        rst = 1'b1;
        insn_vld = 1'b1;
        insn_half = 16'h8001;
        @(negedge clk);
        #5;
        check("R1", "cur_mode after mid-run reset", int'(cur_mode), 0);
        check("R1", "resv_flag after mid-run reset", int'(resv_flag), 0);
        rst = 1'b0;
        insn_vld = 1'b0;
        @(negedge clk);
        #5;
        check("R1", "cur_mode holds FULL32", int'(cur_mode), 0);
        check("R6", "no flag after reset", int'(resv_flag), 0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule